// File: doc/BRIEF.md
# 100 Mb/s Link Integrity Monitor

This block decides when a 100 Mb/s link may carry traffic. It watches a signal-energy indication from the receive front end. Energy has to stay present for a programmable number of clock cycles before the link counts as qualified. The block then waits in a ready state until the auto-negotiation logic grants the link, or it moves on at once when auto-negotiation is configured off. Only in the up state are transmit and receive enabled. Losing energy at any point drops the link immediately, and qualification then starts again from zero.

The 100 Mb/s link state is ORed with the 10 Mb/s link status. The result drives a live link indication for an LED or activity pin. It also drives a status bit that latches low: once the combined link goes down, the bit stays low until a read strobe samples it. Software therefore always sees a drop, even if the drop was brief.

Top module: `link_integrity_monitor`

## Requirements
- R1: The 100 Mb/s link qualifies only after `energy_det` has been sampled high on QUAL_CYCLES consecutive clock edges. When grant or bypass is already present, `link100_up` rises at the edge that is the (QUAL_CYCLES+2)-th consecutive edge with energy high, and not earlier.
- R2: In the ready state, with `an_disable` low, `link100_up` stays low as long as `an_grant` is low. It rises on the edge after `an_grant` is sampled high.
- R3: With `an_disable` high, the block goes from ready to up one edge later without any grant.
- R4: `txrx_en` is high exactly when `link100_up` is high, so transmit and receive are halted whenever the link is not up.
- R5: `link_led` equals `link100_up` OR `link10_up` and follows `link10_up` within the same cycle.
- R6: An edge that samples `energy_det` low makes `link100_up` low after that edge, from any state. Qualification then needs a full fresh run of QUAL_CYCLES edges with energy high.
- R7: `link_stat` updates at each clock edge. When `status_rd` is high, it loads the current `link_led`. Otherwise it clears to 0 when `link_led` is low, and holds its value in every other case. A link that comes back up after a drop therefore reads 0 until a read strobe.
- R8: While `rst_n` is low, `link100_up`, `txrx_en` and `link_stat` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| energy_det | input | 1 | Signal energy present on the receive line |
| an_grant | input | 1 | Link enable from auto-negotiation |
| an_disable | input | 1 | Configuration: auto-negotiation off, skip the grant wait |
| link10_up | input | 1 | 10 Mb/s link status |
| status_rd | input | 1 | Read strobe for the latched status bit |
| link100_up | output | 1 | 100 Mb/s link is up |
| txrx_en | output | 1 | Transmit and receive enable |
| link_led | output | 1 | Live combined link status |
| link_stat | output | 1 | Latched-low combined link status bit |

## Verification
The bench goes after the boundary of the qualification count. A timer that is off by one raises `link100_up` one edge early or one edge late at the (QUAL_CYCLES+2)-th edge. It also drops energy for a single cycle just before qualification would complete. A timer that fails to restart would then bring the link up too soon. It holds the ready state with no grant for many cycles and toggles the bypass bit, which exposes a design that treats a missing grant as permission. It drops and restores the link between status reads, which catches a status bit that follows the live link instead of latching low.

// File: rtl/lim_pkg.sv
package lim_pkg;

  typedef enum logic [1:0] {
    LS_DOWN  = 2'd0,
    LS_READY = 2'd1,
    LS_UP    = 2'd2
  } link_state_t;

  // saturating increment of the energy run counter
  function automatic int unsigned run_next(input int unsigned cur,
                                           input int unsigned limit,
                                           input logic        energy);
    if (!energy)          return 0;
    else if (cur < limit) return cur + 1;
    else                  return cur;
  endfunction

  function automatic logic combine_link(input logic up100, input logic up10);
    return up100 | up10;
  endfunction

  // latch-low status bit update
  function automatic logic stat_next(input logic cur, input logic live,
                                     input logic rd);
    if (rd)         return live;
    else if (!live) return 1'b0;
    else            return cur;
  endfunction

endpackage

// File: rtl/lim_qual_timer.sv
module lim_qual_timer #(
  parameter int unsigned QUAL_CYCLES = 62500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic energy_det,
  output logic qual_done
);
  import lim_pkg::*;

  localparam int unsigned CW = $clog2(QUAL_CYCLES + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= CW'(run_next(int'(run_q), QUAL_CYCLES, energy_det));
  end

  assign qual_done = (run_q == CW'(QUAL_CYCLES));

endmodule

// File: rtl/lim_link_fsm.sv
module lim_link_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic energy_det,
  input  logic qual_done,
  input  logic an_grant,
  input  logic an_disable,
  output logic in_ready,
  output logic in_up
);
  import lim_pkg::*;

  link_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!energy_det) begin
      st_d = LS_DOWN;
    end else begin
      unique case (st_q)
        LS_DOWN:  if (qual_done) st_d = LS_READY;
        LS_READY: if (an_disable || an_grant) st_d = LS_UP;
        LS_UP:    st_d = LS_UP;
        default:  st_d = LS_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LS_DOWN;
    else        st_q <= st_d;
  end

  assign in_ready = (st_q == LS_READY);
  assign in_up    = (st_q == LS_UP);

endmodule

// File: rtl/lim_status_bit.sv
module lim_status_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic rd,
  output logic stat
);
  import lim_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= 1'b0;
    else        stat <= stat_next(stat, live, rd);
  end

endmodule

// File: rtl/link_integrity_monitor.sv
module link_integrity_monitor #(
  parameter int unsigned QUAL_CYCLES = 62500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic energy_det,
  input  logic an_grant,
  input  logic an_disable,
  input  logic link10_up,
  input  logic status_rd,
  output logic link100_up,
  output logic txrx_en,
  output logic link_led,
  output logic link_stat
);
  import lim_pkg::*;

  logic qual_done;
  logic in_ready;
  logic in_up;

  lim_qual_timer #(.QUAL_CYCLES(QUAL_CYCLES)) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .energy_det(energy_det),
    .qual_done (qual_done)
  );

  lim_link_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .energy_det(energy_det),
    .qual_done (qual_done),
    .an_grant  (an_grant),
    .an_disable(an_disable),
    .in_ready  (in_ready),
    .in_up     (in_up)
  );

  assign link100_up = in_up;
  assign txrx_en    = in_up;
  assign link_led   = combine_link(in_up, link10_up);

  lim_status_bit i_stat (
    .clk  (clk),
    .rst_n(rst_n),
    .live (link_led),
    .rd   (status_rd),
    .stat (link_stat)
  );

endmodule

// File: rtl/lim_checker.sv
module lim_checker (
  input logic clk,
  input logic rst_n,
  input logic energy_det,
  input logic an_grant,
  input logic an_disable,
  input logic link10_up,
  input logic status_rd,
  input logic link100_up,
  input logic txrx_en,
  input logic link_led,
  input logic link_stat,
  input logic qual_done,
  input logic in_ready
);

  assert_ready_needs_qual_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(qual_done));

  assert_qual_needs_energy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    qual_done |-> $past(energy_det));

  assert_up_needs_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link100_up) |-> $past(in_ready) && ($past(an_grant) || $past(an_disable)));

  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && an_disable && energy_det |=> link100_up);

  assert_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !link100_up |-> !txrx_en);

  assert_led_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link10_up |-> link_led);

  assert_drop_on_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !energy_det |=> !link100_up && !in_ready);

  assert_latch_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !status_rd && !link_led |=> !link_stat);

endmodule

bind link_integrity_monitor lim_checker i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .energy_det(energy_det),
  .an_grant  (an_grant),
  .an_disable(an_disable),
  .link10_up (link10_up),
  .status_rd (status_rd),
  .link100_up(link100_up),
  .txrx_en   (txrx_en),
  .link_led  (link_led),
  .link_stat (link_stat),
  .qual_done (qual_done),
  .in_ready  (in_ready)
);

// File: tb/test_link_integrity_monitor.sv
`timescale 1ns/100ps
module test_link_integrity_monitor;

  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic energy_det = 1'b0, an_grant = 1'b0, an_disable = 1'b0;
  logic link10_up = 1'b0, status_rd = 1'b0;
  logic link100_up, txrx_en, link_led, link_stat;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit model_on = 0;

  always #2.5 clk = ~clk;

  link_integrity_monitor #(.QUAL_CYCLES(Q)) i_link_integrity_monitor (
    .clk(clk), .rst_n(rst_n), .energy_det(energy_det), .an_grant(an_grant),
    .an_disable(an_disable), .link10_up(link10_up), .status_rd(status_rd),
    .link100_up(link100_up), .txrx_en(txrx_en), .link_led(link_led),
    .link_stat(link_stat)
  );

  // reference model: 0 = no link, 1 = waiting for grant, 2 = link up
  int m_run = 0;
  int m_phase = 0;
  bit m_stat = 0;

  function automatic bit m_live(int phase, bit l10);
    return (phase == 2) || l10;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run <= 0; m_phase <= 0; m_stat <= 0;
    end else begin
      if (!energy_det)                           m_phase <= 0;
      else if (m_phase == 0 && m_run >= Q)       m_phase <= 1;
      else if (m_phase == 1 && (an_grant || an_disable)) m_phase <= 2;
      m_run <= energy_det ? ((m_run < Q) ? m_run + 1 : m_run) : 0;
      if (status_rd)                        m_stat <= m_live(m_phase, link10_up);
      else if (!m_live(m_phase, link10_up)) m_stat <= 0;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !done) begin
      chk(link100_up, m_phase == 2, "R1/R2/R3/R6 model link100_up");
      chk(txrx_en,    m_phase == 2, "R4 model txrx_en");
      chk(link_led,   m_live(m_phase, link10_up), "R5 model link_led");
      chk(link_stat,  m_stat, "R7 model link_stat");
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    tick(3);
    chk(link100_up, 1'b0, "R8 reset link100_up");
    chk(txrx_en,    1'b0, "R8 reset txrx_en");
    chk(link_stat,  1'b0, "R8 reset link_stat");
    rst_n = 1'b1;
    model_on = 1;
    tick(1);

    // R1 and R3: bypass, exact qualification edge
    an_disable = 1; energy_det = 1;
    tick(Q + 1);
    chk(link100_up, 1'b0, "R1 not up one edge early");
    tick(1);
    chk(link100_up, 1'b1, "R1/R3 up at Q+2 edges");
    chk(txrx_en,    1'b1, "R4 enabled when up");

    // R6: loss in up
    energy_det = 0;
    tick(1);
    chk(link100_up, 1'b0, "R6 drop on loss");
    chk(txrx_en,    1'b0, "R4 halted when down");

    // R2: wait for grant
    an_disable = 0; an_grant = 0; energy_det = 1;
    tick(Q + 30);
    chk(link100_up, 1'b0, "R2 held without grant");
    an_grant = 1;
    tick(1);
    chk(link100_up, 1'b1, "R2 up after grant");
    an_grant = 0;
    energy_det = 0;
    tick(1);
    chk(link100_up, 1'b0, "R6 drop from up");

    // R6: glitch restarts qualification
    an_disable = 1; energy_det = 1;
    tick(Q);
    energy_det = 0;
    tick(1);
    energy_det = 1;
    tick(Q + 1);
    chk(link100_up, 1'b0, "R6 restart after glitch");
    tick(1);
    chk(link100_up, 1'b1, "R6 up after fresh run");

    // R5: 10 Mb/s status merges
    energy_det = 0; link10_up = 1;
    tick(1);
    chk(link_led, 1'b1, "R5 led from 10M");
    link10_up = 0; #0.5;
    chk(link_led, 1'b0, "R5 led low");

    // R7: latch low
    status_rd = 1; energy_det = 1;
    tick(1);
    status_rd = 0;
    chk(link_stat, 1'b0, "R7 read while down");
    tick(Q + 2);
    chk(link100_up, 1'b1, "R7 link back up");
    chk(link_stat,  1'b0, "R7 held low until read");
    status_rd = 1;
    tick(1);
    status_rd = 0;
    chk(link_stat, 1'b1, "R7 read loads live");
    energy_det = 0;
    tick(1);
    energy_det = 1;
    tick(Q + 3);
    chk(link_stat, 1'b0, "R7 brief drop kept");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      energy_det = ($urandom % 16) != 0;
      an_grant   = ($urandom % 8) == 0;
      if (($urandom % 64) == 0) an_disable = ~an_disable;
      link10_up  = ($urandom % 4) == 0;
      status_rd  = ($urandom % 5) == 0;
      tick(1);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule